// File: doc/BRIEF.md
# Whole-Pulse Burst Gate

This block lets a burst of pulses from a free-running pulse train reach its output while an active-low enable strobe is asserted. The strobe has no fixed timing relation to the pulse train, so a plain AND of the two would cut the first or last pulse of a burst short. Here the gating decision is held in one state bit. That bit may change only while the pulse input is low. As a result, every pulse that reaches the output has the full width of the input pulse it came from.

The pulse train and the strobe are both sampled by a fast system clock through multi-flop synchronizers. The gating logic works on the synchronized samples, and the output is registered.

If the strobe is activated while a pulse is already high, that partial pulse is dropped. A sticky status bit records the drop and keeps its value until the next strobe activation, so downstream logic has time to read it. If the strobe is released during a pulse, that pulse finishes in full and no later pulse is passed.

Top module: `burst_gate`

## Requirements
- R1: While rst_ni is low, pulse_o and cut_o are 0 and the gate is closed.
- R2: With the default two synchronizer stages, pulse_o equals pulse_i delayed by three clk_i cycles whenever the gate is open for the whole pulse.
- R3: The gate state changes only while the synchronized pulse input is low, so every pulse_o pulse is exactly as wide as its input pulse.
- R4: If en_ni falls while the synchronized pulse input is low, the next pulse is passed and cut_o becomes 0.
- R5: If en_ni falls while the synchronized pulse input is high, that pulse is not passed and cut_o becomes 1.
- R6: cut_o keeps its value until the next falling edge of en_ni, including after en_ni rises.
- R7: If en_ni rises while a passed pulse is high, that pulse completes in full and no later pulse appears on pulse_o.
- R8: pulse_o is never high unless pulse_i was high three cycles earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast system clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pulse_i | input | 1 | Free-running pulse train, asynchronous |
| en_ni | input | 1 | Enable strobe, active low, asynchronous |
| pulse_o | output | 1 | Gated pulse train, whole pulses only |
| cut_o | output | 1 | Sticky flag: first pulse after activation was dropped |

## Verification
The assertions rely on each high and low phase of pulse_i lasting longer than the synchronizer depth, and on en_ni staying at a level for several clk_i cycles, so that no edge is lost in synchronization. The stimulus drives pulse_i with a fixed period of five cycles high and seven cycles low. It then places strobe edges both in directed pulse phases and at random phases, holding each strobe level for at least ten cycles. A behavioural model predicts pulse_o and cut_o for every cycle, and separate checks measure each output pulse width.

// File: rtl/burst_gate_pkg.sv
package burst_gate_pkg;
  parameter int unsigned DEF_SYNC_STAGES = 2;

  typedef struct packed {
    logic pulse;
    logic act;
  } smp_t;
endpackage

// File: rtl/bg_sync.sv
module bg_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= RST_VAL;
        else         sh_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= {STAGES{RST_VAL}};
        else         sh_q <= {sh_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/bg_gate_core.sv
module bg_gate_core (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic g_i,
  input  logic act_i,
  output logic y_o
);
  logic z_q, z_n, y_q;

  // decision may only move while the pulse is low
  assign z_n = g_i ? z_q : act_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      z_q <= 1'b0;
      y_q <= 1'b0;
    end else begin
      z_q <= z_n;
      y_q <= g_i & z_n;
    end
  end

  assign y_o = y_q;

  // R3
  z_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    g_i ##1 g_i |-> $stable(z_q));

  // R8
  no_out_without_in_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    y_q |-> $past(g_i));

  // R3
  no_rise_while_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(y_q) |-> !$past(y_q) && $past(g_i) && $past(g_i, 2) == 1'b0);
endmodule

// File: rtl/bg_cut_flag.sv
module bg_cut_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic g_i,
  input  logic act_i,
  output logic cut_o
);
  logic act_d, cut_q, act_rise;

  assign act_rise = act_i & ~act_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_d <= 1'b0;
      cut_q <= 1'b0;
    end else begin
      act_d <= act_i;
      if (act_rise) cut_q <= g_i;
    end
  end

  assign cut_o = cut_q;

  // R5
  cut_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i && !act_d && g_i |=> cut_q);

  // R4
  cut_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i && !act_d && !g_i |=> !cut_q);

  // R6
  cut_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(act_i && !act_d) |=> $stable(cut_q));
endmodule

// File: rtl/burst_gate.sv
module burst_gate
  import burst_gate_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pulse_i,
  input  logic en_ni,
  output logic pulse_o,
  output logic cut_o
);
  smp_t s;
  logic en_n_s;

  bg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_pulse (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pulse_i), .q_o(s.pulse)
  );

  bg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_en (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(en_ni), .q_o(en_n_s)
  );

  assign s.act = ~en_n_s;

  bg_gate_core u_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .g_i(s.pulse), .act_i(s.act), .y_o(pulse_o)
  );

  bg_cut_flag u_flag (
    .clk_i(clk_i), .rst_ni(rst_ni), .g_i(s.pulse), .act_i(s.act), .cut_o(cut_o)
  );
endmodule

// File: tb/burst_gate_test.sv
module burst_gate_test;
  localparam int HI  = 5;
  localparam int LO  = 7;
  localparam int PER = HI + LO;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pulse_i = 1'b0;
  logic en_n = 1'b1;
  logic pulse_o, cut_o;

  int total = 0;
  int bad = 0;
  int ph = 0;
  int out_rises = 0;
  int wcnt = 0;
  logic prev_o = 1'b0;
  bit done = 0;

  // model state
  bit qg[$];
  bit qe[$];
  bit mz, my, mf, mact_d, mg_used;

  always #4 clk = ~clk;

  burst_gate uut (
    .clk_i(clk), .rst_ni(rst_n), .pulse_i(pulse_i), .en_ni(en_n),
    .pulse_o(pulse_o), .cut_o(cut_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // free-running pulse train
  initial begin
    forever begin
      @(negedge clk);
      ph = (ph == PER - 1) ? 0 : ph + 1;
      pulse_i = (ph < HI);
    end
  end

  // behavioural reference
  always @(posedge clk or negedge rst_n) begin
    bit gs, act, zn;
    if (!rst_n) begin
      qg = '{0, 0};
      qe = '{1, 1};
      mz = 0; my = 0; mf = 0; mact_d = 0; mg_used = 0;
    end else begin
      gs  = qg[0];
      act = !qe[0];
      zn  = gs ? mz : act;
      my  = gs & zn;
      if (act && !mact_d) mf = gs;
      mz = zn;
      mact_d = act;
      mg_used = gs;
      void'(qg.pop_front()); qg.push_back(pulse_i);
      void'(qe.pop_front()); qe.push_back(en_n);
    end
  end

  // per-cycle compare, away from the edge
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      check(pulse_o === my, "R2", pulse_o, my);
      check(cut_o === mf, "R6", cut_o, mf);
      if (pulse_o) check(mg_used == 1'b1, "R8", pulse_o, 0);
      if (pulse_o && !prev_o) out_rises++;
      if (pulse_o) wcnt++;
      else if (prev_o) begin
        check(wcnt == HI, "R3", wcnt, HI);
        wcnt = 0;
      end
      prev_o = pulse_o;
    end
  end

  task automatic wait_ph(input int target);
    do begin
      @(negedge clk);
      #1;
    end while (ph != target);
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    int n0;
    int hold_c;
    bit keep;
    // R1
    repeat (3) @(negedge clk);
    #1;
    check(pulse_o === 1'b0, "R1", pulse_o, 0);
    check(cut_o === 1'b0, "R1", cut_o, 0);
    rst_n = 1'b1;
    cycles(2 * PER);
    check(out_rises == 0, "R1", out_rises, 0);

    // R4: activation during low phase
    wait_ph(HI + 2);
    en_n = 1'b0;
    n0 = out_rises;
    cycles(4);
    check(cut_o === 1'b0, "R4", cut_o, 0);
    cycles(PER);
    check(out_rises - n0 == 1, "R4", out_rises - n0, 1);

    // R7: release during passed pulse
    wait_ph(4);
    en_n = 1'b1;
    cycles(1);
    n0 = out_rises;
    cycles(3 * PER);
    check(out_rises - n0 == 0, "R7", out_rises - n0, 0);

    // R5: activation during high phase
    wait_ph(1);
    en_n = 1'b0;
    n0 = out_rises;
    cycles(5);
    check(cut_o === 1'b1, "R5", cut_o, 1);
    check(out_rises == n0, "R5", out_rises - n0, 0);
    cycles(PER);
    check(out_rises - n0 == 1, "R5", out_rises - n0, 1);
    wait_ph(HI + 3);
    en_n = 1'b1;
    cycles(2 * PER);
    check(cut_o === 1'b1, "R6", cut_o, 1);

    // random strobe placement
    for (int i = 0; i < 60; i++) begin
      cycles(10 + ($urandom % (3 * PER)));
      en_n = 1'b0;
      hold_c = 10 + ($urandom % 50);
      cycles(hold_c);
      keep = cut_o;
      en_n = 1'b1;
      cycles(10 + ($urandom % 20));
      check(cut_o === keep, "R6", cut_o, keep);
    end
    cycles(2 * PER);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule